// File: doc/BRIEF.md
# Two-Stage Gated JTAG Scan Chain

This block chains two IEEE 1149.1 test access ports behind one set of TCK, TMS, TRST and TDI pins. The TDI pin enters the debug-side port first. Its serial output feeds the device-side port, and the device-side port drives the TDO pin. Each port has its own 16-state controller, its own instruction register (4 bits on the debug side, 6 bits on the device side), a 1-bit bypass register and a 32-bit identification register. Both controllers see the same TMS stream, so they always move in lockstep. Each one still decodes its own instruction.

Either port can be removed from the chain. While the processor-side reset-release input is high, the debug-side port is removed. The device-side port is removed when its fuse input or its configuration input is set. A removed port does not break the chain: it is replaced by a one-bit stage in both the instruction path and the data path. A removed port also ignores any instruction the host tries to load.

Top module: `jtag_dual_chain`

## Requirements
- R1: The serial order is tdi → debug-side port → device-side port → tdo. With both ports present, the instruction path is 10 bits long. The 6 device-side bits leave tdo first.
- R2: In Capture-IR each instruction register loads 1 in bit 0 and 0 in all higher bits. Bits leave least significant bit first. With both ports present, the first 10 tdo bits of an instruction scan are 1,0,0,0,0,0,1,0,0,0.
- R3: In Test-Logic-Reset each port selects its identification instruction: 4'b1110 on the debug side and 6'b001001 on the device side. A data scan then returns 32'h1C84E093 (device side) followed by 32'h3BA05C2D (debug side), each least significant bit first.
- R4: The all-ones instruction selects the 1-bit bypass register, which captures 0. Any other opcode that is not the identification opcode also selects bypass.
- R5: Driving trst_n low forces both controllers into Test-Logic-Reset at once, with no TCK edge needed, and drives tdo_oe low.
- R6: Five consecutive TCK rising edges with tms high bring both controllers to Test-Logic-Reset from any state.
- R7: tdo and tdo_oe change only on the falling edge of tck. tdo_oe is high only while the controllers are in Shift-IR or Shift-DR.
- R8: While cpu_active is high, the debug-side port is replaced by a single stage that captures 0. The instruction path then shrinks to 7 bits (1 + 6).
- R9: While cpu_active is high, Update-IR leaves the debug-side instruction register unchanged.
- R10: If fuse_dis or cfg_dis is high, the device-side port is replaced by a single stage that captures 0.
- R11: The two ports decode instructions independently, so each can hold a different instruction at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data into the debug-side port |
| cpu_active | input | 1 | High while the processor is out of reset; removes the debug-side port |
| fuse_dis | input | 1 | Fuse-based disable of the device-side port |
| cfg_dis | input | 1 | Configuration-based disable of the device-side port |
| tdo | output | 1 | Serial data out of the device-side port, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for tdo; low means high-impedance |

## Verification
Some properties are checked on every TCK rising edge:
- Both controllers stay in the same state.
- A controller is in Test-Logic-Reset after a reset release.
- A controller is in Test-Logic-Reset after five TMS-high edges.
- The output enable tracks the shift states.
- A removed debug-side port keeps its instruction across Update-IR.

Only the bench scenarios can show the following:
- The bit order and length of the whole chain under each gating combination.
- The identification values as they arrive at tdo.
- That an instruction blocked during gating is still in force once gating is lifted.

// File: rtl/jtag_chain_pkg.sv
package jtag_chain_pkg;

   typedef enum logic [3:0] {
      ST_TLR    = 4'h0,
      ST_RTI    = 4'h1,
      ST_SEL_DR = 4'h2,
      ST_CAP_DR = 4'h3,
      ST_SH_DR  = 4'h4,
      ST_EX1_DR = 4'h5,
      ST_PAU_DR = 4'h6,
      ST_EX2_DR = 4'h7,
      ST_UPD_DR = 4'h8,
      ST_SEL_IR = 4'h9,
      ST_CAP_IR = 4'hA,
      ST_SH_IR  = 4'hB,
      ST_EX1_IR = 4'hC,
      ST_PAU_IR = 4'hD,
      ST_EX2_IR = 4'hE,
      ST_UPD_IR = 4'hF
   } tap_state_e;

   localparam int unsigned ID_W = 32;

   function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
      case (s)
         ST_TLR:    return m ? ST_TLR    : ST_RTI;
         ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
         ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
         ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
         ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
         default:   return m ? ST_SEL_DR : ST_RTI;
      endcase
   endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import jtag_chain_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e state
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= ST_TLR;
      else         state <= tap_next(state, tms);
   end

   // run of TMS-high edges, saturating at five
   logic [2:0] hi_run;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)        hi_run <= 3'd0;
      else if (!tms)      hi_run <= 3'd0;
      else if (hi_run < 3'd5) hi_run <= hi_run + 3'd1;
   end

   AST_TRST_TLR: assert property (@(posedge tck) disable iff (!trst_n)
      !$past(trst_n) |-> state == ST_TLR);                          // R5

   AST_TMS_FIVE: assert property (@(posedge tck) disable iff (!trst_n)
      hi_run == 3'd5 |-> state == ST_TLR);                          // R6

endmodule

// File: rtl/tap_unit.sv
module tap_unit
   import jtag_chain_pkg::*;
#(
   parameter int unsigned          IR_W   = 4,
   parameter bit                   HAS_ID = 1'b1,
   parameter logic [IR_W-1:0]      ID_OP  = '0,
   parameter logic [ID_W-1:0]      ID_VAL = 32'h0000_0001
)(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   input  logic       si,
   input  logic       gated,
   output logic       so,
   output logic       oe,
   output tap_state_e state_o
);

   localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-1){1'b0}}, 1'b1};
   localparam logic [IR_W-1:0] RST_IR  = HAS_ID ? ID_OP : {IR_W{1'b1}};

   if (IR_W < 2) begin : g_bad_width
      $error("tap_unit: IR_W must be at least 2");
   end
   if (HAS_ID && (ID_OP == {IR_W{1'b1}})) begin : g_bad_op
      $error("tap_unit: identification opcode collides with bypass");
   end
   if (HAS_ID && !ID_VAL[0]) begin : g_bad_id
      $error("tap_unit: identification value must have bit 0 set");
   end

   tap_state_e st;
   tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(st));
   assign state_o = st;

   logic [IR_W-1:0] ir_sr, ir_q;
   logic            byp;
   logic            id_bit;
   logic            sel_id;
   logic            ser;
   logic            in_shift;

   assign in_shift = (st == ST_SH_IR) || (st == ST_SH_DR);
   assign sel_id   = HAS_ID && !gated && (ir_q == ID_OP);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_q  <= RST_IR;
         ir_sr <= '0;
         byp   <= 1'b0;
      end else begin
         case (st)
            ST_TLR:    ir_q  <= RST_IR;
            ST_CAP_IR: begin ir_sr <= CAP_PAT; byp <= 1'b0; end
            ST_SH_IR:  begin ir_sr <= {si, ir_sr[IR_W-1:1]}; byp <= si; end
            ST_UPD_IR: if (!gated) ir_q <= ir_sr;
            ST_CAP_DR: byp <= 1'b0;
            ST_SH_DR:  byp <= si;
            default:   ;
         endcase
      end
   end

   if (HAS_ID) begin : g_id
      logic [ID_W-1:0] id_sr;
      always_ff @(posedge tck or negedge trst_n) begin
         if (!trst_n)             id_sr <= '0;
         else if (st == ST_CAP_DR) id_sr <= ID_VAL;
         else if (st == ST_SH_DR)  id_sr <= {si, id_sr[ID_W-1:1]};
      end
      assign id_bit = id_sr[0];
   end else begin : g_no_id
      assign id_bit = 1'b0;
   end

   always_comb begin
      if (st == ST_SH_IR)      ser = gated ? byp : ir_sr[0];
      else if (st == ST_SH_DR) ser = sel_id ? id_bit : byp;
      else                     ser = byp;
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         so <= 1'b0;
         oe <= 1'b0;
      end else begin
         oe <= in_shift;
         if (in_shift) so <= ser;
      end
   end

   AST_OE_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
      oe == in_shift);                                              // R7

   AST_GATED_IR_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
      (gated && st == ST_UPD_IR) |=> $stable(ir_q));                // R9

endmodule

// File: rtl/jtag_dual_chain.sv
module jtag_dual_chain
   import jtag_chain_pkg::*;
#(
   parameter int unsigned      DBG_IR_W  = 4,
   parameter int unsigned      DEV_IR_W  = 6,
   parameter logic [DBG_IR_W-1:0] DBG_ID_OP = 4'b1110,
   parameter logic [DEV_IR_W-1:0] DEV_ID_OP = 6'b001001,
   parameter logic [ID_W-1:0]  DBG_ID    = 32'h3BA0_5C2D,
   parameter logic [ID_W-1:0]  DEV_ID    = 32'h1C84_E093
)(
   input  logic tck,
   input  logic trst_n,
   input  logic tms,
   input  logic tdi,
   input  logic cpu_active,
   input  logic fuse_dis,
   input  logic cfg_dis,
   output logic tdo,
   output logic tdo_oe
);

   logic       link;
   logic       dbg_oe;
   logic       dev_gate;
   tap_state_e dbg_st, dev_st;

   assign dev_gate = fuse_dis | cfg_dis;

   tap_unit #(
      .IR_W(DBG_IR_W), .HAS_ID(1'b1), .ID_OP(DBG_ID_OP), .ID_VAL(DBG_ID)
   ) u_dbg (
      .tck(tck), .trst_n(trst_n), .tms(tms), .si(tdi), .gated(cpu_active),
      .so(link), .oe(dbg_oe), .state_o(dbg_st)
   );

   tap_unit #(
      .IR_W(DEV_IR_W), .HAS_ID(1'b1), .ID_OP(DEV_ID_OP), .ID_VAL(DEV_ID)
   ) u_dev (
      .tck(tck), .trst_n(trst_n), .tms(tms), .si(link), .gated(dev_gate),
      .so(tdo), .oe(tdo_oe), .state_o(dev_st)
   );

   AST_LOCKSTEP: assert property (@(posedge tck) disable iff (!trst_n)
      dbg_st == dev_st);                                            // R11

   AST_OE_ALIGN: assert property (@(posedge tck) disable iff (!trst_n)
      dbg_oe == tdo_oe);                                            // R7

endmodule

// File: tb/test_jtag_dual_chain.sv
module test_jtag_dual_chain;

   localparam logic [31:0] DBG_ID = 32'h3BA0_5C2D;
   localparam logic [31:0] DEV_ID = 32'h1C84_E093;

   // {cpu_active, fuse_dis, cfg_dis, expected 12 tdo bits of an IR scan}
   localparam logic [14:0] VEC [0:5] = '{
      15'h0C41, 15'h4F81, 15'h2FE2, 15'h1FE2, 15'h7FFC, 15'h6FFC
   };

   logic tck = 1'b0;
   logic trst_n = 1'b0;
   logic tms = 1'b1, tdi = 1'b0;
   logic cpu_active = 1'b0, fuse_dis = 1'b0, cfg_dis = 1'b0;
   logic tdo, tdo_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 tck = ~tck;

   jtag_dual_chain i_jtag_dual_chain (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
      .cpu_active(cpu_active), .fuse_dis(fuse_dis), .cfg_dis(cfg_dis),
      .tdo(tdo), .tdo_oe(tdo_oe)
   );

   task automatic check(input bit ok, input string req,
                        input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input logic m, input logic d);
      tms = m; tdi = d;
      @(posedge tck);
      #6;
   endtask

   task automatic to_tlr();
      for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
      tick(1'b0, 1'b0);
   endtask

   // from Run-Test/Idle: scan n bits, return to Run-Test/Idle
   task automatic scan(input bit ir, input int n, input logic [127:0] din,
                       output logic [127:0] dout, output bit oe_ok);
      tick(1'b1, 1'b0);
      if (ir) tick(1'b1, 1'b0);
      tick(1'b0, 1'b0);
      tick(1'b0, 1'b0);
      dout = '0;
      dout[0] = tdo;
      oe_ok = tdo_oe;
      for (int i = 0; i < n; i++) begin
         tick(i == n - 1, din[i]);
         if (i < n - 1) begin
            dout[i+1] = tdo;
            oe_ok &= tdo_oe;
         end
      end
      oe_ok &= !tdo_oe;
      tick(1'b1, 1'b0);
      tick(1'b0, 1'b0);
   endtask

   function automatic logic [127:0] exp_dr(input bit g1, input bit d2);
      logic [127:0] v = '1;
      int p = 0;
      if (d2) begin v[0] = 1'b0; p = 1; end
      else    begin v[31:0] = DEV_ID; p = 32; end
      if (g1) v[p] = 1'b0;
      else    v[p +: 32] = DBG_ID;
      return v;
   endfunction

   logic [127:0] dout, m70, m12;
   bit oe_ok;

   initial begin
      m70 = (128'd1 << 70) - 1;
      m12 = (128'd1 << 12) - 1;
      repeat (3) @(posedge tck);
      #6;
      check(tdo_oe == 1'b0, "R5 reset oe", {127'd0, tdo_oe}, 128'd0);
      trst_n = 1'b1;
      tick(1'b0, 1'b0);

      // vector table
      for (int v = 0; v < 6; v++) begin
         cpu_active = VEC[v][14];
         fuse_dis   = VEC[v][13];
         cfg_dis    = VEC[v][12];
         to_tlr();  // R6 path reset
         scan(1'b0, 70, '1, dout, oe_ok);
         check((dout & m70) == (exp_dr(VEC[v][14], VEC[v][13] | VEC[v][12]) & m70),
               "R3/R8/R10 data path", dout & m70,
               exp_dr(VEC[v][14], VEC[v][13] | VEC[v][12]) & m70);
         check(oe_ok, "R7 oe during DR scan", {127'd0, oe_ok}, 128'd1);
         scan(1'b1, 12, '1, dout, oe_ok);
         check((dout & m12) == {116'd0, VEC[v][11:0]},
               "R1/R2/R8/R10 instruction path", dout & m12, {116'd0, VEC[v][11:0]});
         check(oe_ok, "R7 oe during IR scan", {127'd0, oe_ok}, 128'd1);
      end
      cpu_active = 1'b0; fuse_dis = 1'b0; cfg_dis = 1'b0;

      // R11 and R4: debug side gets 0101 (unknown), device side IDCODE
      to_tlr();
      scan(1'b1, 10, {118'd0, 4'b0101, 6'b001001}, dout, oe_ok);
      scan(1'b0, 70, '1, dout, oe_ok);
      check((dout & m70) == (exp_dr(1'b1, 1'b0) & m70), "R11 R4 mixed opcodes",
            dout & m70, exp_dr(1'b1, 1'b0) & m70);

      // R11 R3: debug side IDCODE, device side all ones
      scan(1'b1, 10, {118'd0, 4'b1110, 6'b111111}, dout, oe_ok);
      scan(1'b0, 70, '1, dout, oe_ok);
      check((dout & m70) == (exp_dr(1'b0, 1'b1) & m70), "R11 R3 reversed opcodes",
            dout & m70, exp_dr(1'b0, 1'b1) & m70);

      // R9: instruction blocked while gated, still IDCODE afterwards
      cpu_active = 1'b1;
      to_tlr();
      scan(1'b1, 7, '1, dout, oe_ok);
      cpu_active = 1'b0;
      scan(1'b0, 70, '1, dout, oe_ok);
      check((dout & m70) == (exp_dr(1'b0, 1'b1) & m70), "R9 gated update ignored",
            dout & m70, exp_dr(1'b0, 1'b1) & m70);

      // R5: asynchronous reset in the middle of Shift-DR
      scan(1'b1, 10, '1, dout, oe_ok);
      tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
      check(tdo_oe == 1'b1, "R7 oe in Shift-DR", {127'd0, tdo_oe}, 128'd1);
      trst_n = 1'b0;
      #1;
      check(tdo_oe == 1'b0, "R5 async oe drop", {127'd0, tdo_oe}, 128'd0);
      trst_n = 1'b1;
      tick(1'b0, 1'b0);
      scan(1'b0, 70, '1, dout, oe_ok);
      check((dout & m70) == (exp_dr(1'b0, 1'b0) & m70), "R5 IDCODE after trst",
            dout & m70, exp_dr(1'b0, 1'b0) & m70);

      // R6: five TMS-high edges from Shift-IR
      scan(1'b1, 10, '1, dout, oe_ok);
      tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
      for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
      tick(1'b0, 1'b0);
      scan(1'b0, 70, '1, dout, oe_ok);
      check((dout & m70) == (exp_dr(1'b0, 1'b0) & m70), "R6 TMS reset",
            dout & m70, exp_dr(1'b0, 1'b0) & m70);

      // R7: tdo holds through the rising edge, changes after the falling edge
      tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
      check(tdo == 1'b1, "R2 first IR bit", {127'd0, tdo}, 128'd1);
      tms = 1'b0; tdi = 1'b0;
      @(posedge tck);
      #1;
      check(tdo == 1'b1, "R7 tdo stable after rising edge", {127'd0, tdo}, 128'd1);
      #5;
      check(tdo == 1'b0, "R7 tdo after falling edge", {127'd0, tdo}, 128'd0);
      to_tlr();

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge tck);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule